// File: doc/BRIEF.md
# Parallel DAC Bus Write Sequencer

This block sits on the host side of a four-channel, 12-bit converter that has a parallel bus. The host logic asks for one operation at a time over a valid/ready handshake. The operation can be a channel write, a channel readback, a global load strobe or a converter clear. The sequencer then produces the address pins, the read/write level, an active-low chip select, the write data with its output enable, an active-low load strobe and an active-low clear. Each of these waveforms holds for whole clock cycles, and every minimum pulse width and every setup or hold window is met.

Every minimum is given as a parameter in nanoseconds. The block turns each one into cycles at the chosen clock period, rounding up, so the timing stays correct when the clock changes. A readback samples the converter's data bus on the last cycle that chip select is low. The sampled word appears on the response port together with a one-cycle done flag. A write can optionally keep the load strobe low around its chip-select window, so the converter updates its output as the word arrives.

Top module: `dbs_bus_seq`

## Requirements
- R1: After reset, chip select, load and clear are high, the write-data enable and the response flag are low, read/write is high, the address is 0 and `req_ready` is high.
- R2: The address pins carry the requested channel code: bit 1 is set for channels C and D (codes 2 and 3), and bit 0 is set for channels B and D (codes 1 and 3).
- R3: Address, read/write level, write data and the write-data enable keep their values for the whole chip-select-low window, for at least one cycle before chip select falls and for at least one cycle after it rises.
- R4: A write (op code 0) drives read/write low and keeps chip select low for exactly 10 cycles at the default 5 ns period, which is 50 ns rounded up.
- R5: A read (op code 1) drives read/write high for 2 cycles before chip select falls, which is 10 ns. It then keeps chip select low for exactly 40 cycles, which is 200 ns and is never shorter than the 160 ns data-valid delay.
- R6: A read samples the converter data bus on the last chip-select-low cycle. The sampled word is shown on `rsp_rdata` in the cycle where `rsp_done` is high.
- R7: The write-data enable is high only while read/write is low, and only during write accesses.
- R8: A load request (op code 2) drives the load strobe low for 10 cycles and leaves chip select high.
- R9: A write with `req_hold_load` set pulls the load strobe low 14 cycles (70 ns) before chip select falls. The strobe stays low for 10 cycles (50 ns) after chip select rises.
- R10: A clear request (op code 3) drives the clear output low for 10 cycles and leaves chip select high.
- R11: Chip select stays high for at least one gap cycle before a new request is accepted. After a read, the write-data enable stays low for at least 20 cycles (100 ns) after chip select rises.
- R12: `req_ready` is high only while the sequencer is idle, and requests made while it is low are ignored. `rsp_done` is a single-cycle pulse once per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted this cycle if valid |
| req_op | input | 2 | 0 write, 1 read, 2 load, 3 clear |
| req_chan | input | 2 | Channel code 0..3 (A..D) |
| req_data | input | 12 | Word to write |
| req_hold_load | input | 1 | Write with load strobe held low around chip select |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 12 | Word sampled by the latest read |
| dac_addr | output | 2 | Channel select pins |
| dac_rnw | output | 1 | High for read, low for write |
| dac_cs_n | output | 1 | Chip select, active low |
| dac_wdata | output | 12 | Write data toward the converter |
| dac_wdata_oe | output | 1 | Enable for the host's data-bus drivers |
| dac_rdata | input | 12 | Data returned by the converter |
| dac_load_n | output | 1 | Load strobe, active low |
| dac_clear_n | output | 1 | Converter clear, active low |

## Verification
The hardest case to reach from the ports is a read whose data is valid only late in the chip-select window. The bench's converter model returns a poison word until chip select has been low for 32 cycles. As a result, only a capture on the final low cycle returns the word written earlier to that channel. A second hard case is a request offered while the sequencer is busy. The bench raises `req_valid` with a write in the middle of a read and then reads that channel back, to show that no stray write reached the bus.

// File: rtl/dbs_pkg.sv
`timescale 1ns/1ps
package dbs_pkg;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_READ  = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD,
        PH_PULSE,
        PH_GAP
    } phase_e;

    // Minimum time in ns -> whole cycles at period_ps, rounded up, at least one.
    function automatic int ns2cyc(input int ns, input int period_ps);
        int c;
        c = (ns * 1000 + period_ps - 1) / period_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dbs_phase_timer.sv
`timescale 1ns/1ps
module dbs_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] len_m1_i,
    output logic             last_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load_i)
            cnt_d = len_m1_i;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last_o = (cnt_q == '0);
endmodule

// File: rtl/dbs_rd_capture.sv
`timescale 1ns/1ps
module dbs_rd_capture #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [DATA_W-1:0] bus_i,
    output logic [DATA_W-1:0] word_o
);
    logic [DATA_W-1:0] word_d, word_q;

    always_comb word_d = en_i ? bus_i : word_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end

    assign word_o = word_q;
endmodule

// File: rtl/dbs_bus_seq.sv
`timescale 1ns/1ps
module dbs_bus_seq
    import dbs_pkg::*;
#(
    parameter int DATA_W          = 12,
    parameter int CH_W            = 2,
    parameter int CLK_PERIOD_PS   = 5000,
    parameter int T_CS_WR_NS      = 50,
    parameter int T_CS_RD_NS      = 200,
    parameter int T_RD_SETUP_NS   = 10,
    parameter int T_RD_VALID_NS   = 160,
    parameter int T_RD_RELEASE_NS = 100,
    parameter int T_LD_PULSE_NS   = 50,
    parameter int T_LD_LEAD_NS    = 70,
    parameter int T_LD_TRAIL_NS   = 50,
    parameter int T_CLR_NS        = 50,
    parameter int GAP_CYC         = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [CH_W-1:0]   req_chan,
    input  logic [DATA_W-1:0] req_data,
    input  logic              req_hold_load,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [CH_W-1:0]   dac_addr,
    output logic              dac_rnw,
    output logic              dac_cs_n,
    output logic [DATA_W-1:0] dac_wdata,
    output logic              dac_wdata_oe,
    input  logic [DATA_W-1:0] dac_rdata,
    output logic              dac_load_n,
    output logic              dac_clear_n
);
    // Cycle counts derived from the ns minima.
    localparam int CS_WR_C  = ns2cyc(T_CS_WR_NS, CLK_PERIOD_PS);
    localparam int CS_RD_C  = imax(ns2cyc(T_CS_RD_NS, CLK_PERIOD_PS),
                                   ns2cyc(T_RD_VALID_NS, CLK_PERIOD_PS) + 1);
    localparam int RD_SU_C  = ns2cyc(T_RD_SETUP_NS, CLK_PERIOD_PS);
    localparam int RD_REL_C = imax(ns2cyc(T_RD_RELEASE_NS, CLK_PERIOD_PS), GAP_CYC);
    localparam int LD_PW_C  = ns2cyc(T_LD_PULSE_NS, CLK_PERIOD_PS);
    localparam int LD_LD_C  = ns2cyc(T_LD_LEAD_NS, CLK_PERIOD_PS);
    localparam int LD_TR_C  = ns2cyc(T_LD_TRAIL_NS, CLK_PERIOD_PS);
    localparam int CLR_C    = ns2cyc(T_CLR_NS, CLK_PERIOD_PS);
    localparam int GAP_C    = imax(GAP_CYC, 1);
    localparam int MAX_C    = imax(imax(imax(CS_WR_C, CS_RD_C), imax(RD_SU_C, RD_REL_C)),
                                   imax(imax(LD_PW_C, LD_LD_C), imax(imax(LD_TR_C, CLR_C), GAP_C)));
    localparam int CNT_W    = $clog2(MAX_C + 1);

    typedef struct packed {
        phase_e            ph;
        op_e               op;
        logic              with_ld;
        logic              cs_n;
        logic              rnw;
        logic [CH_W-1:0]   addr;
        logic              oe;
        logic [DATA_W-1:0] wdata;
        logic              ld_n;
        logic              clr_n;
        logic              done;
    } seq_t;

    localparam seq_t SEQ_RST = '{
        ph: PH_IDLE, op: OP_WRITE, with_ld: 1'b0, cs_n: 1'b1, rnw: 1'b1,
        addr: '0, oe: 1'b0, wdata: '0, ld_n: 1'b1, clr_n: 1'b1, done: 1'b0
    };

    seq_t             seq_d, seq_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_len_m1;
    logic             tmr_last;
    logic             cap_en;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        tmr_load   = 1'b0;
        tmr_len_m1 = '0;
        cap_en     = 1'b0;

        unique case (seq_q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    seq_d.op      = op_e'(req_op);
                    seq_d.with_ld = 1'b0;
                    tmr_load      = 1'b1;
                    unique case (op_e'(req_op))
                        OP_WRITE: begin
                            seq_d.ph      = PH_SETUP;
                            seq_d.addr    = req_chan;
                            seq_d.rnw     = 1'b0;
                            seq_d.oe      = 1'b1;
                            seq_d.wdata   = req_data;
                            seq_d.with_ld = req_hold_load;
                            seq_d.ld_n    = ~req_hold_load;
                            tmr_len_m1    = req_hold_load ? CNT_W'(LD_LD_C - 1) : '0;
                        end
                        OP_READ: begin
                            seq_d.ph   = PH_SETUP;
                            seq_d.addr = req_chan;
                            seq_d.rnw  = 1'b1;
                            tmr_len_m1 = CNT_W'(RD_SU_C - 1);
                        end
                        OP_LOAD: begin
                            seq_d.ph   = PH_PULSE;
                            seq_d.ld_n = 1'b0;
                            tmr_len_m1 = CNT_W'(LD_PW_C - 1);
                        end
                        default: begin
                            seq_d.ph    = PH_PULSE;
                            seq_d.clr_n = 1'b0;
                            tmr_len_m1  = CNT_W'(CLR_C - 1);
                        end
                    endcase
                end
            end
            PH_SETUP: begin
                if (tmr_last) begin
                    seq_d.ph   = PH_STROBE;
                    seq_d.cs_n = 1'b0;
                    tmr_load   = 1'b1;
                    tmr_len_m1 = (seq_q.op == OP_READ) ? CNT_W'(CS_RD_C - 1)
                                                       : CNT_W'(CS_WR_C - 1);
                end
            end
            PH_STROBE: begin
                if (tmr_last) begin
                    cap_en     = (seq_q.op == OP_READ);
                    seq_d.ph   = PH_HOLD;
                    seq_d.cs_n = 1'b1;
                    tmr_load   = 1'b1;
                    tmr_len_m1 = seq_q.with_ld ? CNT_W'(LD_TR_C - 1) : '0;
                end
            end
            PH_HOLD: begin
                if (tmr_last) begin
                    seq_d.ph    = PH_GAP;
                    seq_d.rnw   = 1'b1;
                    seq_d.addr  = '0;
                    seq_d.oe    = 1'b0;
                    seq_d.wdata = '0;
                    seq_d.ld_n  = 1'b1;
                    tmr_load    = 1'b1;
                    tmr_len_m1  = (seq_q.op == OP_READ) ? CNT_W'(RD_REL_C - 1)
                                                        : CNT_W'(GAP_C - 1);
                end
            end
            PH_PULSE: begin
                if (tmr_last) begin
                    seq_d.ph    = PH_GAP;
                    seq_d.ld_n  = 1'b1;
                    seq_d.clr_n = 1'b1;
                    tmr_load    = 1'b1;
                    tmr_len_m1  = CNT_W'(GAP_C - 1);
                end
            end
            PH_GAP: begin
                if (tmr_last) begin
                    seq_d.ph   = PH_IDLE;
                    seq_d.done = 1'b1;
                end
            end
            default: seq_d = SEQ_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= SEQ_RST;
        else        seq_q <= seq_d;
    end

    dbs_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (tmr_load),
        .len_m1_i (tmr_len_m1),
        .last_o   (tmr_last)
    );

    dbs_rd_capture #(.DATA_W(DATA_W)) u_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (cap_en),
        .bus_i  (dac_rdata),
        .word_o (rsp_rdata)
    );

    assign req_ready    = (seq_q.ph == PH_IDLE);
    assign rsp_done     = seq_q.done;
    assign dac_addr     = seq_q.addr;
    assign dac_rnw      = seq_q.rnw;
    assign dac_cs_n     = seq_q.cs_n;
    assign dac_wdata    = seq_q.wdata;
    assign dac_wdata_oe = seq_q.oe;
    assign dac_load_n   = seq_q.ld_n;
    assign dac_clear_n  = seq_q.clr_n;
endmodule

// File: rtl/dbs_seq_checker.sv
`timescale 1ns/1ps
module dbs_seq_checker #(
    parameter int DATA_W   = 12,
    parameter int CH_W     = 2,
    parameter int CS_WR_C  = 10,
    parameter int CS_RD_C  = 40,
    parameter int RD_REL_C = 20,
    parameter int LD_PW_C  = 10,
    parameter int LD_LD_C  = 14,
    parameter int LD_TR_C  = 10,
    parameter int CLR_C    = 10,
    parameter int GAP_C    = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_done,
    input logic [CH_W-1:0]   dac_addr,
    input logic              dac_rnw,
    input logic              dac_cs_n,
    input logic [DATA_W-1:0] dac_wdata,
    input logic              dac_wdata_oe,
    input logic              dac_load_n,
    input logic              dac_clear_n
);
    localparam logic [15:0] SAT = 16'hFFFF;

    logic [15:0] cs_lo, cs_hi, ld_lo, clr_lo, since_rd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_lo    <= '0;
            cs_hi    <= SAT;
            ld_lo    <= '0;
            clr_lo   <= '0;
            since_rd <= SAT;
        end else begin
            cs_lo    <= dac_cs_n ? 16'd0 : cs_lo + 16'd1;
            cs_hi    <= !dac_cs_n ? 16'd0 : ((cs_hi == SAT) ? cs_hi : cs_hi + 16'd1);
            ld_lo    <= dac_load_n ? 16'd0 : ld_lo + 16'd1;
            clr_lo   <= dac_clear_n ? 16'd0 : clr_lo + 16'd1;
            since_rd <= (!dac_cs_n && dac_rnw) ? 16'd0
                      : ((since_rd == SAT) ? since_rd : since_rd + 16'd1);
        end
    end

    assert_bus_stable_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_cs_n |-> ($stable(dac_addr) && $stable(dac_rnw) && $stable(dac_wdata) && $stable(dac_wdata_oe)));

    assert_bus_hold_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_cs_n) |-> ($stable(dac_addr) && $stable(dac_rnw) && $stable(dac_wdata) && $stable(dac_wdata_oe)));

    // Covers R5 as well: read windows are checked against CS_RD_C.
    assert_cs_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_cs_n) |-> (cs_lo == (dac_rnw ? 16'(CS_RD_C) : 16'(CS_WR_C))));

    assert_oe_write_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dac_wdata_oe |-> !dac_rnw);

    assert_load_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_load_n) |-> (ld_lo >= 16'(LD_PW_C)));

    assert_load_lead_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dac_cs_n) && !dac_load_n) |-> (ld_lo >= 16'(LD_LD_C)));

    assert_load_trail_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_load_n) |-> (cs_hi >= 16'(LD_TR_C)));

    assert_clear_width_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_clear_n) |-> (clr_lo >= 16'(CLR_C)));

    assert_accept_gap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> (cs_hi >= 16'(GAP_C)));

    assert_read_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        dac_wdata_oe |-> (since_rd >= 16'(RD_REL_C)));

    assert_ready_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (dac_cs_n && dac_load_n && dac_clear_n && !dac_wdata_oe));

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
endmodule

bind dbs_bus_seq dbs_seq_checker #(
    .DATA_W   (DATA_W),
    .CH_W     (CH_W),
    .CS_WR_C  (CS_WR_C),
    .CS_RD_C  (CS_RD_C),
    .RD_REL_C (RD_REL_C),
    .LD_PW_C  (LD_PW_C),
    .LD_LD_C  (LD_LD_C),
    .LD_TR_C  (LD_TR_C),
    .CLR_C    (CLR_C),
    .GAP_C    (GAP_C)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .rsp_done     (rsp_done),
    .dac_addr     (dac_addr),
    .dac_rnw      (dac_rnw),
    .dac_cs_n     (dac_cs_n),
    .dac_wdata    (dac_wdata),
    .dac_wdata_oe (dac_wdata_oe),
    .dac_load_n   (dac_load_n),
    .dac_clear_n  (dac_clear_n)
);

// File: tb/tb_dbs_bus_seq.sv
`timescale 1ns/1ps
module tb_dbs_bus_seq;
    // Expected cycle counts at a 5 ns clock, worked out by hand from the ns minima.
    localparam int E_CS_WR  = 10;
    localparam int E_CS_RD  = 40;
    localparam int E_RD_SU  = 2;
    localparam int E_RD_REL = 20;
    localparam int E_LD_PW  = 10;
    localparam int E_LD_LD  = 14;
    localparam int E_LD_TR  = 10;
    localparam int E_CLR    = 10;
    localparam int E_GAP    = 1;
    localparam int VALID_AFTER = 32;   // converter data valid after 160 ns low
    localparam logic [11:0] POISON = 12'hBAD;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = '0;
    logic [1:0]  req_chan = '0;
    logic [11:0] req_data = '0;
    logic        req_hold_load = 1'b0;
    logic        rsp_done;
    logic [11:0] rsp_rdata;
    logic [1:0]  dac_addr;
    logic        dac_rnw, dac_cs_n, dac_wdata_oe, dac_load_n, dac_clear_n;
    logic [11:0] dac_wdata;
    logic [11:0] dac_rdata;

    always #2.5 clk = ~clk;

    dbs_bus_seq dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_chan(req_chan), .req_data(req_data), .req_hold_load(req_hold_load),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .dac_addr(dac_addr), .dac_rnw(dac_rnw), .dac_cs_n(dac_cs_n),
        .dac_wdata(dac_wdata), .dac_wdata_oe(dac_wdata_oe), .dac_rdata(dac_rdata),
        .dac_load_n(dac_load_n), .dac_clear_n(dac_clear_n)
    );

    // Converter model: input registers, late read data, clear to zero.
    logic [11:0] chip_mem [4];
    logic        cs_prev = 1'b1;
    int          low_cnt = 0;
    always @(posedge clk) begin
        if (!dac_clear_n) begin
            for (int i = 0; i < 4; i++) chip_mem[i] <= '0;
        end else if (!cs_prev && dac_cs_n && !dac_rnw) begin
            chip_mem[dac_addr] <= dac_wdata;
        end
        cs_prev <= dac_cs_n;
        low_cnt <= dac_cs_n ? 0 : low_cnt + 1;
    end
    initial for (int i = 0; i < 4; i++) chip_mem[i] = '0;
    assign dac_rdata = (!dac_cs_n && dac_rnw && low_cnt >= VALID_AFTER) ? chip_mem[dac_addr] : POISON;

    // Reference model: queue of expected per-cycle outputs.
    // vector = {done, ready, cs_n, rnw, addr[1:0], oe, wdata[11:0], load_n, clear_n}
    logic [20:0] exp_q[$];
    string       tag_q[$];
    int          rd_q[$];
    logic [11:0] shadow [4];
    int          checks = 0;
    int          errors = 0;
    string       idle_tag = "R1";

    function automatic logic [20:0] vec(bit done, bit rdy, bit cs, bit rnw, logic [1:0] a,
                                        bit oe, logic [11:0] wd, bit ld, bit cl);
        return {done, rdy, cs, rnw, a, oe, wd, ld, cl};
    endfunction

    task automatic push(int n, logic [20:0] v, string tag);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(v); tag_q.push_back(tag); rd_q.push_back(-1);
        end
    endtask

    task automatic push_done(int rd);
        exp_q.push_back(vec(1, 1, 1, 1, 2'd0, 0, 12'd0, 1, 1));
        tag_q.push_back("R12");
        rd_q.push_back(rd);
    endtask

    task automatic step();
        logic [20:0] e, a;
        string t;
        int rd;
        @(negedge clk);
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front(); t = tag_q.pop_front(); rd = rd_q.pop_front();
        end else begin
            e = vec(0, 1, 1, 1, 2'd0, 0, 12'd0, 1, 1); t = idle_tag; rd = -1;
        end
        a = {rsp_done, req_ready, dac_cs_n, dac_rnw, dac_addr, dac_wdata_oe, dac_wdata, dac_load_n, dac_clear_n};
        checks++;
        if (a !== e) begin
            errors++;
            $display("FAIL %s: outputs got %h expected %h at %0t", t, a, e, $time);
        end
        if (!e[18]) begin   // chip select expected low: address check R2
            checks++;
            if (dac_addr !== e[16:15]) begin
                errors++;
                $display("FAIL R2: addr got %0d expected %0d", dac_addr, e[16:15]);
            end
        end
        checks++;
        if (dac_wdata_oe && dac_rnw) begin
            errors++;
            $display("FAIL R7: oe got 1 expected 0 while rnw high");
        end
        if (rd >= 0) begin
            checks++;
            if (rsp_rdata !== rd[11:0]) begin
                errors++;
                $display("FAIL R6: rdata got %h expected %h", rsp_rdata, rd[11:0]);
            end
        end
    endtask

    task automatic issue(int op, int ch, logic [11:0] data, bit hl);
        logic [1:0] a;
        while (exp_q.size() > 0) step();
        a = ch[1:0];
        req_valid = 1'b1; req_op = op[1:0]; req_chan = a; req_data = data; req_hold_load = hl;
        idle_tag = "R11";
        case (op)
            0: begin
                if (hl) begin
                    push(E_LD_LD, vec(0, 0, 1, 0, a, 1, data, 0, 1), "R9");
                    push(E_CS_WR, vec(0, 0, 0, 0, a, 1, data, 0, 1), "R4");
                    push(E_LD_TR, vec(0, 0, 1, 0, a, 1, data, 0, 1), "R9");
                end else begin
                    push(1,       vec(0, 0, 1, 0, a, 1, data, 1, 1), "R3");
                    push(E_CS_WR, vec(0, 0, 0, 0, a, 1, data, 1, 1), "R4");
                    push(1,       vec(0, 0, 1, 0, a, 1, data, 1, 1), "R3");
                end
                push(E_GAP, vec(0, 0, 1, 1, 2'd0, 0, 12'd0, 1, 1), "R11");
                push_done(-1);
                shadow[ch] = data;
            end
            1: begin
                push(E_RD_SU,  vec(0, 0, 1, 1, a, 0, 12'd0, 1, 1), "R5");
                push(E_CS_RD,  vec(0, 0, 0, 1, a, 0, 12'd0, 1, 1), "R5");
                push(1,        vec(0, 0, 1, 1, a, 0, 12'd0, 1, 1), "R3");
                push(E_RD_REL, vec(0, 0, 1, 1, 2'd0, 0, 12'd0, 1, 1), "R11");
                push_done(int'(shadow[ch]));
            end
            2: begin
                push(E_LD_PW, vec(0, 0, 1, 1, 2'd0, 0, 12'd0, 0, 1), "R8");
                push(E_GAP,   vec(0, 0, 1, 1, 2'd0, 0, 12'd0, 1, 1), "R11");
                push_done(-1);
            end
            default: begin
                push(E_CLR, vec(0, 0, 1, 1, 2'd0, 0, 12'd0, 1, 0), "R10");
                push(E_GAP, vec(0, 0, 1, 1, 2'd0, 0, 12'd0, 1, 1), "R11");
                push_done(-1);
                for (int i = 0; i < 4; i++) shadow[i] = '0;
            end
        endcase
        step();
        req_valid = 1'b0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: run did not finish");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) shadow[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state held while idle.
        repeat (3) step();
        // R2 R4 R3: plain writes to every channel.
        issue(0, 0, 12'h123, 0);
        issue(0, 1, 12'hABC, 0);
        issue(0, 2, 12'h800, 0);
        issue(0, 3, 12'hFFF, 0);
        // R5 R6: readbacks, data valid only late in the window.
        issue(1, 3, 12'h000, 0);
        issue(1, 0, 12'h000, 0);
        issue(1, 1, 12'h000, 0);
        // R12: request offered while busy is ignored.
        repeat (5) step();
        req_valid = 1'b1; req_op = 2'd0; req_chan = 2'd2; req_data = 12'h0F0;
        step();
        req_valid = 1'b0;
        issue(1, 2, 12'h000, 0);   // still 800: stray write never happened
        // R9: write with load held around chip select.
        issue(0, 2, 12'h555, 1);
        issue(1, 2, 12'h000, 0);
        // R8: standalone load pulse.
        issue(2, 0, 12'h000, 0);
        // R10: clear, then read returns zero.
        issue(3, 0, 12'h000, 0);
        issue(1, 3, 12'h000, 0);
        // R11: write directly after a read (release window).
        issue(0, 1, 12'h3C3, 0);
        issue(1, 1, 12'h000, 0);
        while (exp_q.size() > 0) step();
        repeat (3) step();
        summary();
        $finish;
    end
endmodule